// File: doc/BRIEF.md
# Floppy Controller Wait-State Generator

This block sits between a CPU bus and a floppy disk controller chip. Its job is to stall the CPU on data-register accesses until the controller is ready, and to decode the controller's register strobes. When the CPU reads or writes the controller's data register, the block pulls `cpu_ready` low in the same cycle. It then waits for the controller's data request, which it passes through a two-flop synchroniser. After that it counts one or two further system clocks to meet the controller's access time. Only then does it release the access strobes and raise `cpu_ready` again.

A static strap input picks the delay. One clock suits buses up to 3 MHz. Two clocks suits buses up to 6 MHz, and that is the normal setting. Either the controller's interrupt request or reset ends a pending wait at once, so an error during a disk transfer cannot leave the CPU stalled. The status, track and sector registers (and the command register) are reached without any wait. The command-register write strobe is decoded separately.

Top module: `fdc_wait_gen`

## Requirements
- R1: A data-register access drives `cpu_ready` low in the same cycle while no wait is in progress. A data-register access means `board_sel`=1, `bus_addr`=3'b011, and `cpu_rd_n` or `cpu_wr_n` low.
- R2: While the controller's data request has not arrived, a pending wait is never released and `cpu_ready` stays low.
- R3: Suppose `fdc_drq` rises between clock edges k and k+1 during a pending wait. With `strap_two`=0, `cpu_ready` rises after edge k+3. With `strap_two`=1, it rises after edge k+4.
- R4: While `fdc_intrq` is high, `cpu_ready` is high. A pending wait seen with `fdc_intrq` high is released on the next edge, and it stays released after `fdc_intrq` falls until the access ends.
- R5: While `rst` is high, `cpu_ready` is high and no wait is held. After reset, all strobes are inactive when no access is driven.
- R6: An access to address 0, 1 or 2 with `board_sel`=1 never lowers `cpu_ready`, and it drives `fdc_en_n` low in the same cycle.
- R7: `fdc_en_n` stays high throughout a pending wait. It goes low once the wait has been released and stays low while the access continues.
- R8: `fdc_wr_n` is low exactly when `fdc_en_n` and `cpu_wr_n` are both low. `fdc_rd_n` is low exactly when `fdc_en_n` and `cpu_rd_n` are both low.
- R9: `fdc_cmd_wr` is high only during an enabled write to address 3'b000.
- R10: Once the strobes have been inactive for a clock, a following data-register access receives the full synchronisation and delay again.
- R11: With `board_sel`=0 or `bus_addr[2]`=1, `cpu_ready` stays high and `fdc_en_n`, `fdc_rd_n` and `fdc_wr_n` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Low CPU address bits |
| board_sel | input | 1 | Board select, active high |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| strap_two | input | 1 | Static delay strap: 1 selects two clocks, 0 selects one |
| fdc_drq | input | 1 | Controller data request, asynchronous |
| fdc_intrq | input | 1 | Controller interrupt request |
| cpu_ready | output | 1 | Ready to the CPU, low holds a wait state |
| fdc_en_n | output | 1 | Controller enable, active low |
| fdc_rd_n | output | 1 | Controller read strobe, active low |
| fdc_wr_n | output | 1 | Controller write strobe, active low |
| fdc_cmd_wr | output | 1 | Command-register write strobe, active high |

## Verification
The assertions assume that `strap_two` changes only while no data-register access is in progress. They also assume that an access holds its address and strobe steady until the CPU sees ready. The stimulus obeys both rules: it changes the strap only between accesses, it keeps every access stable until `cpu_ready` has been observed, and it leaves at least two idle clocks after each data transfer so the synchroniser drains. The random mix draws register kinds, strap settings, read or write direction, and data-request delays. Directed cases cover the interrupt abort, a reset in mid-wait, and a request that is already high when the access starts.

// File: rtl/fdc_wait_pkg.sv
package fdc_wait_pkg;

    localparam int DLY_W    = 2;
    localparam int REG_W    = 2;
    localparam int DATA_IDX = 3;
    localparam int CMD_IDX  = 0;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_WAIT = 2'd1,
        WS_DONE = 2'd2
    } ws_state_e;

    typedef struct packed {
        logic hit;
        logic data;
        logic cmd;
    } dec_s;

    function automatic logic [DLY_W-1:0] delay_load(input logic two);
        return two ? DLY_W'(2) : DLY_W'(1);
    endfunction

endpackage

// File: rtl/fdc_sync.sv
module fdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/fdc_reg_decode.sv
module fdc_reg_decode
    import fdc_wait_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              board_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    output dec_s              dec
);
    localparam int HI_W = ADDR_W - REG_W;

    logic              upper_zero;
    logic [REG_W-1:0]  reg_idx;

    assign upper_zero = (addr[ADDR_W-1:REG_W] == HI_W'(0));
    assign reg_idx    = addr[REG_W-1:0];

    always_comb begin
        dec.hit  = board_sel && upper_zero && (!rd_n || !wr_n);
        dec.data = dec.hit && (reg_idx == REG_W'(DATA_IDX));
        dec.cmd  = dec.hit && (reg_idx == REG_W'(CMD_IDX));
    end
endmodule

// File: rtl/fdc_wait_fsm.sv
module fdc_wait_fsm
    import fdc_wait_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acc_data,
    input  logic drq_s,
    input  logic intrq,
    input  logic strap_two,
    output logic ready,
    output logic released
);
    ws_state_e        state, state_nx;
    logic [DLY_W-1:0] cnt;
    logic             cnt_last;

    assign cnt_last = (cnt == DLY_W'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE: if (acc_data) state_nx = intrq ? WS_DONE : WS_WAIT;
            WS_WAIT: begin
                if (!acc_data)                state_nx = WS_IDLE;
                else if (intrq)               state_nx = WS_DONE;
                else if (drq_s && cnt_last)   state_nx = WS_DONE;
            end
            WS_DONE: if (!acc_data) state_nx = WS_IDLE;
            default: state_nx = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WS_IDLE;
            cnt   <= delay_load(strap_two);
        end else begin
            state <= state_nx;
            if (state != WS_WAIT)
                cnt <= delay_load(strap_two);
            else if (drq_s && !cnt_last)
                cnt <= cnt - DLY_W'(1);
        end
    end

    assign ready    = rst || intrq || !acc_data || (state == WS_DONE);
    assign released = (state == WS_DONE);

    assert_no_early_release_R2: assert property (@(posedge clk) disable iff (rst)
        (state == WS_WAIT && !drq_s && !intrq) |=> (state != WS_DONE));

    assert_intrq_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (state == WS_WAIT && intrq && acc_data) |=> (state == WS_DONE));

    assert_cnt_live_R3: assert property (@(posedge clk) disable iff (rst)
        (state == WS_WAIT) |-> (cnt != DLY_W'(0)));

    assert_full_reload_R10: assert property (@(posedge clk) disable iff (rst)
        (state == WS_IDLE && acc_data && !intrq) |=>
        (state == WS_WAIT && cnt == delay_load($past(strap_two))));
endmodule

// File: rtl/fdc_wait_gen.sv
module fdc_wait_gen
    import fdc_wait_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              board_sel,
    input  logic              cpu_rd_n,
    input  logic              cpu_wr_n,
    input  logic              strap_two,
    input  logic              fdc_drq,
    input  logic              fdc_intrq,
    output logic              cpu_ready,
    output logic              fdc_en_n,
    output logic              fdc_rd_n,
    output logic              fdc_wr_n,
    output logic              fdc_cmd_wr
);
    dec_s dec;
    logic drq_s;
    logic released;
    logic go;

    fdc_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .board_sel (board_sel),
        .rd_n      (cpu_rd_n),
        .wr_n      (cpu_wr_n),
        .dec       (dec)
    );

    fdc_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (fdc_drq),
        .d_out (drq_s)
    );

    fdc_wait_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .acc_data  (dec.data),
        .drq_s     (drq_s),
        .intrq     (fdc_intrq),
        .strap_two (strap_two),
        .ready     (cpu_ready),
        .released  (released)
    );

    assign go         = dec.hit && (!dec.data || released);
    assign fdc_en_n   = !go;
    assign fdc_rd_n   = fdc_en_n || cpu_rd_n;
    assign fdc_wr_n   = fdc_en_n || cpu_wr_n;
    assign fdc_cmd_wr = dec.cmd && !fdc_wr_n;

    assert_nondata_no_wait_R6: assert property (@(posedge clk) disable iff (rst)
        (dec.hit && !dec.data) |-> (cpu_ready && !fdc_en_n));

    assert_wait_blocks_enable_R7: assert property (@(posedge clk) disable iff (rst)
        (dec.data && !cpu_ready) |-> fdc_en_n);

    assert_cmd_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        fdc_cmd_wr |-> (bus_addr == ADDR_W'(0) && !cpu_wr_n && board_sel));

    assert_unselected_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!board_sel) |-> (cpu_ready && fdc_en_n && fdc_rd_n && fdc_wr_n));
endmodule

// File: tb/fdc_wait_gen_tb.sv
module fdc_wait_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic       board_sel = 1'b0;
    logic       cpu_rd_n = 1'b1;
    logic       cpu_wr_n = 1'b1;
    logic       strap_two = 1'b1;
    logic       fdc_drq = 1'b0;
    logic       fdc_intrq = 1'b0;
    logic       cpu_ready, fdc_en_n, fdc_rd_n, fdc_wr_n, fdc_cmd_wr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    fdc_wait_gen u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .board_sel(board_sel),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .strap_two(strap_two),
        .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq), .cpu_ready(cpu_ready),
        .fdc_en_n(fdc_en_n), .fdc_rd_n(fdc_rd_n), .fdc_wr_n(fdc_wr_n),
        .fdc_cmd_wr(fdc_cmd_wr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_en_n(input logic sel, input logic [2:0] a,
                                    input logic rn, input logic wn);
        return (sel && a[2] == 1'b0 && a[1:0] != 2'd3 && (!rn || !wn)) ? 0 : 1;
    endfunction

    function automatic int exp_delay(input logic two);
        return two ? 4 : 3;
    endfunction

    task automatic bus_idle();
        @(negedge clk);
        board_sel = 0; cpu_rd_n = 1; cpu_wr_n = 1; bus_addr = 0; fdc_drq = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic data_access(input logic wr, input logic two, input int pre);
        int n;
        @(negedge clk);
        strap_two = two;
        @(negedge clk);
        board_sel = 1; bus_addr = 3'd3;
        if (wr) cpu_wr_n = 0; else cpu_rd_n = 0;
        #1;
        chk("R1 ready low on data access", cpu_ready, 0);
        chk("R7 enable held during wait", fdc_en_n, 1);
        for (int i = 0; i < pre; i++) begin
            @(negedge clk);
            chk("R2 no release without drq", cpu_ready, 0);
        end
        fdc_drq = 1;
        n = 0;
        while (n < 10) begin
            @(negedge clk);
            n++;
            if (cpu_ready) break;
        end
        chk("R3 drq to ready edges", n, exp_delay(two));
        chk("R7 enable after release", fdc_en_n, 0);
        chk("R8 write strobe", fdc_wr_n, wr ? 0 : 1);
        chk("R8 read strobe", fdc_rd_n, wr ? 1 : 0);
        chk("R9 no cmd strobe on data reg", fdc_cmd_wr, 0);
        @(negedge clk);
        chk("R7 enable stays low", fdc_en_n, 0);
        bus_idle();
    endtask

    task automatic plain_access(input logic sel, input logic [2:0] a, input logic wr);
        @(negedge clk);
        board_sel = sel; bus_addr = a;
        if (wr) cpu_wr_n = 0; else cpu_rd_n = 0;
        #1;
        chk(sel && !a[2] ? "R6 ready stays high" : "R11 ready stays high", cpu_ready, 1);
        chk(sel && !a[2] ? "R6 enable" : "R11 enable", fdc_en_n,
            exp_en_n(sel, a, cpu_rd_n, cpu_wr_n));
        chk("R8 wr strobe", fdc_wr_n, (exp_en_n(sel, a, cpu_rd_n, cpu_wr_n) == 0 && wr) ? 0 : 1);
        chk("R8 rd strobe", fdc_rd_n, (exp_en_n(sel, a, cpu_rd_n, cpu_wr_n) == 0 && !wr) ? 0 : 1);
        chk("R9 cmd strobe", fdc_cmd_wr, (sel && a == 3'd0 && wr) ? 1 : 0);
        @(negedge clk);
        chk("R6 no wait after edge", cpu_ready, 1);
        @(negedge clk);
        board_sel = 0; cpu_rd_n = 1; cpu_wr_n = 1; bus_addr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int s;
        void'($urandom(32'h5eed1797));
        repeat (3) @(negedge clk);
        chk("R5 ready in reset", cpu_ready, 1);
        chk("R5 enable in reset", fdc_en_n, 1);
        board_sel = 1; bus_addr = 3'd3; cpu_rd_n = 0;
        #1;
        chk("R5 reset holds no wait", cpu_ready, 1);
        @(negedge clk);
        cpu_rd_n = 1; board_sel = 0; rst = 0;
        @(negedge clk);
        chk("R5 strobes idle after reset", {fdc_en_n, fdc_rd_n, fdc_wr_n, fdc_cmd_wr}, 4'b1110);

        data_access(0, 1, 0);
        data_access(1, 0, 2);
        data_access(1, 1, 3);
        data_access(0, 0, 0);   // R10 full delay again back-to-back

        // drq already high when the access begins
        @(negedge clk);
        strap_two = 0; fdc_drq = 1;
        repeat (3) @(negedge clk);
        board_sel = 1; bus_addr = 3'd3; cpu_rd_n = 0;
        #1;
        chk("R1 ready low with early drq", cpu_ready, 0);
        @(negedge clk);
        chk("R3 one-clock count pending", cpu_ready, 0);
        @(negedge clk);
        chk("R3 released after count", cpu_ready, 1);
        bus_idle();

        // interrupt aborts the wait
        @(negedge clk);
        strap_two = 1;
        @(negedge clk);
        board_sel = 1; bus_addr = 3'd3; cpu_wr_n = 0;
        repeat (2) @(negedge clk);
        chk("R2 still waiting", cpu_ready, 0);
        fdc_intrq = 1;
        #1;
        chk("R4 intrq lifts ready", cpu_ready, 1);
        @(negedge clk);
        fdc_intrq = 0;
        #1;
        chk("R4 stays released", cpu_ready, 1);
        chk("R4 enable after abort", fdc_en_n, 0);
        bus_idle();

        // reset during a wait
        @(negedge clk);
        board_sel = 1; bus_addr = 3'd3; cpu_rd_n = 0;
        repeat (2) @(negedge clk);
        rst = 1;
        #1;
        chk("R5 reset lifts ready", cpu_ready, 1);
        @(negedge clk);
        board_sel = 0; cpu_rd_n = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);

        plain_access(1, 3'd0, 1);   // command write
        plain_access(1, 3'd1, 0);
        plain_access(1, 3'd2, 1);
        plain_access(0, 3'd3, 0);   // R11 unselected
        plain_access(1, 3'd7, 1);   // R11 upper address

        for (int it = 0; it < 60; it++) begin
            s = int'($urandom_range(0, 2));
            if (s == 0)
                data_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                            int'($urandom_range(0, 3)));
            else if (s == 1)
                plain_access(1, 3'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
            else
                plain_access(0, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule